// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Data Path

This block sits between a 16-bit network peripheral and a memory port whose byte order is the reverse of the peripheral's. The peripheral issues one request at a time: a direction (read from memory or write to memory), an offset address, a byte length and a bypass flag. The block ORs the offset with a base value held elsewhere to form the physical address. It then moves 16-bit beats between the peripheral's stream ports and the memory port, one beat per memory handshake.

In the default mode the block clears bit 0 of both the address and the length, and it exchanges the two bytes of every halfword in both directions. Writes in this mode are cut into bursts of at most 64 bytes, and every burst opens with a one-cycle start strobe that carries its address. With the bypass flag set, bytes pass through in stream order at the exact address and length given, and the whole request is one burst. A one-cycle done pulse closes every request.

Top module: `hwswap_dma`

## Requirements
- R1: The address on the first burst strobe of a request equals `req_addr | base_addr`, with bit 0 cleared when bypass is off.
- R2: With bypass off, the length has bit 0 cleared, the block issues length/2 beats, every beat address is even, and every beat has `mem_be = 2'b11`. Beat addresses rise by 2 from the burst address.
- R3: A write with bypass off drives `mem_wdata` as `{src_data[7:0], src_data[15:8]}`.
- R4: A read with bypass off drives `sink_data` as `{mem_rdata[7:0], mem_rdata[15:8]}`.
- R5: With bypass on, the address is used unchanged (odd allowed) and data passes unmodified in both directions. The block issues ceil(length/2) beats, and the last beat of an odd length has `mem_be = 2'b01`, bit 0 marking the low byte.
- R6: A write with bypass off splits into bursts of at most 64 bytes. Each burst is preceded by a single-cycle `mem_burst` with `mem_valid` low, and its address is the request address advanced by 64 per earlier burst.
- R7: Reads, and writes with bypass on, issue exactly one `mem_burst` per request, whatever the length.
- R8: A request whose length is zero after alignment makes no burst and no beat. Its done pulse comes one cycle after acceptance.
- R9: `done` is high for exactly one cycle, in the cycle after the last beat is accepted. `req_ready` returns high in the cycle after that.
- R10: After reset, `req_ready` is high and `mem_valid`, `mem_burst`, `done`, `src_ready` and `sink_valid` are low. A request is accepted only while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_addr | input | AW | Base value ORed into every request address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = stream to memory, 0 = memory to stream |
| req_bypass | input | 1 | 1 = no swap, no alignment, no write splitting |
| req_addr | input | AW | Offset address |
| req_len | input | LW | Length in bytes |
| done | output | 1 | One-cycle pulse at the end of a request |
| src_valid | input | 1 | Write-stream beat available |
| src_ready | output | 1 | Write-stream beat taken |
| src_data | input | 16 | Write-stream beat, first byte in bits 7:0 |
| sink_valid | output | 1 | Read-stream beat delivered |
| sink_ready | input | 1 | Read stream can take a beat |
| sink_data | output | 16 | Read-stream beat, first byte in bits 7:0 |
| mem_burst | output | 1 | Burst start strobe |
| mem_valid | output | 1 | Memory beat offered |
| mem_ready | input | 1 | Memory beat accepted |
| mem_write | output | 1 | Direction of the current request |
| mem_addr | output | AW | Burst or beat address |
| mem_be | output | 2 | Byte enables of the beat |
| mem_wdata | output | 16 | Write beat to memory |
| mem_rdata | input | 16 | Read beat from memory, valid with mem_ready |

## Verification
A wrong byte count or address register shows up on the very next beat as a wrong `mem_addr`. It also shows up at the end of the request as a done pulse one beat early or late. A bad chunk counter moves the `mem_burst` strobe off the 64-byte boundary within one burst of the error. A swap-mode bit that is latched wrongly reverses the byte order of the first data beat, which appears two cycles after acceptance. The bench keeps a queue of expected strobes and beats and compares every port in every cycle, including cycles in which `mem_ready` stalls.

// File: rtl/hwswap_pkg.sv
package hwswap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_XFER  = 2'd2,
        ST_DONE  = 2'd3
    } hs_state_e;
endpackage

// File: rtl/hwswap_addr.sv
module hwswap_addr #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] off_addr,
    input  logic [AW-1:0] base_addr,
    input  logic [LW-1:0] raw_len,
    input  logic          bypass,
    output logic [AW-1:0] phys_addr,
    output logic [LW-1:0] eff_len
);
    logic [AW-1:0] joined;

    always_comb begin
        joined    = off_addr | base_addr;
        phys_addr = joined;
        eff_len   = raw_len;
        if (!bypass) begin
            phys_addr[0] = 1'b0;
            eff_len[0]   = 1'b0;
        end
    end
endmodule

// File: rtl/hwswap_lane.sv
module hwswap_lane #(
    parameter int NBYTES = 2
) (
    input  logic [8*NBYTES-1:0] din,
    input  logic                bypass,
    output logic [8*NBYTES-1:0] dout
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign dout[8*i +: 8] = bypass ? din[8*i +: 8] : din[8*(NBYTES-1-i) +: 8];
    end
endmodule

// File: rtl/hwswap_ctrl.sv
module hwswap_ctrl
    import hwswap_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int CHUNK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_bypass,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          src_valid,
    input  logic          sink_ready,
    input  logic          mem_ready,
    output logic          mem_burst,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic          xfer,
    output logic          wr_mode,
    output logic          byp_mode,
    output logic          done
);
    localparam logic [LW-1:0] CHUNK = LW'(CHUNK_BYTES);
    localparam logic [LW-1:0] TWO   = LW'(2);

    typedef struct packed {
        hs_state_e     st;
        logic          wr;
        logic          byp;
        logic [AW-1:0] addr;
        logic [LW-1:0] rem;
        logic [LW-1:0] crem;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          fire;
    logic [LW-1:0] step;
    logic [LW-1:0] rem_after;

    function automatic logic [LW-1:0] chunk_of(input logic wr, input logic byp,
                                               input logic [LW-1:0] n);
        if (wr && !byp && n > CHUNK) return CHUNK;
        return n;
    endfunction

    always_comb begin
        ctl_d     = ctl_q;
        fire      = mem_valid && mem_ready;
        step      = (ctl_q.rem >= TWO) ? TWO : LW'(1);
        rem_after = ctl_q.rem - step;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.wr   = req_write;
                    ctl_d.byp  = req_bypass;
                    ctl_d.addr = req_addr;
                    ctl_d.rem  = req_len;
                    ctl_d.crem = chunk_of(req_write, req_bypass, req_len);
                    ctl_d.st   = (req_len == '0) ? ST_DONE : ST_BURST;
                end
            end
            ST_BURST: ctl_d.st = ST_XFER;
            ST_XFER: begin
                if (fire) begin
                    ctl_d.addr = ctl_q.addr + AW'(2);
                    ctl_d.rem  = rem_after;
                    ctl_d.crem = ctl_q.crem - step;
                    if (rem_after == '0) begin
                        ctl_d.st = ST_DONE;
                    end else if (ctl_q.crem == step) begin
                        ctl_d.st   = ST_BURST;
                        ctl_d.crem = chunk_of(ctl_q.wr, ctl_q.byp, rem_after);
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign xfer      = (ctl_q.st == ST_XFER);
    assign mem_burst = (ctl_q.st == ST_BURST);
    assign mem_valid = xfer && (ctl_q.wr ? src_valid : sink_ready);
    assign mem_addr  = (mem_burst || xfer) ? ctl_q.addr : '0;
    assign mem_be    = (ctl_q.rem >= TWO) ? 2'b11 : 2'b01;
    assign wr_mode   = ctl_q.wr;
    assign byp_mode  = ctl_q.byp;
    assign done      = (ctl_q.st == ST_DONE);

    AST_BURST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_burst |=> !mem_burst);                                   // R6
    AST_BURST_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_burst |-> !mem_valid);                                   // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));                              // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !mem_burst && !done));          // R10
    AST_EVEN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !byp_mode) |-> (mem_addr[0] == 1'b0 && mem_be == 2'b11)); // R2
    AST_XFER_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (ctl_q.rem != '0));                                 // R8
endmodule

// File: rtl/hwswap_dma.sv
module hwswap_dma #(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int CHUNK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_bypass,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          done,
    input  logic          src_valid,
    output logic          src_ready,
    input  logic [15:0]   src_data,
    output logic          sink_valid,
    input  logic          sink_ready,
    output logic [15:0]   sink_data,
    output logic          mem_burst,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata
);
    logic [AW-1:0] phys_addr;
    logic [LW-1:0] eff_len;
    logic          xfer, wr_mode, byp_mode;

    hwswap_addr #(.AW(AW), .LW(LW)) u_addr (
        .off_addr (req_addr),
        .base_addr(base_addr),
        .raw_len  (req_len),
        .bypass   (req_bypass),
        .phys_addr(phys_addr),
        .eff_len  (eff_len)
    );

    hwswap_ctrl #(.AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_bypass(req_bypass),
        .req_addr  (phys_addr),
        .req_len   (eff_len),
        .src_valid (src_valid),
        .sink_ready(sink_ready),
        .mem_ready (mem_ready),
        .mem_burst (mem_burst),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .xfer      (xfer),
        .wr_mode   (wr_mode),
        .byp_mode  (byp_mode),
        .done      (done)
    );

    hwswap_lane #(.NBYTES(2)) u_wr_lane (
        .din   (src_data),
        .bypass(byp_mode),
        .dout  (mem_wdata)
    );

    hwswap_lane #(.NBYTES(2)) u_rd_lane (
        .din   (mem_rdata),
        .bypass(byp_mode),
        .dout  (sink_data)
    );

    assign mem_write  = wr_mode;
    assign src_ready  = xfer && wr_mode && mem_ready;
    assign sink_valid = xfer && !wr_mode && mem_ready;

    AST_WR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && !byp_mode) |->
        (mem_wdata == {src_data[7:0], src_data[15:8]}));             // R3
    AST_RD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_valid && !byp_mode) |->
        (sink_data == {mem_rdata[7:0], mem_rdata[15:8]}));           // R4
    AST_BYPASS_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && byp_mode) |-> (mem_wdata == src_data)); // R5
endmodule

// File: tb/hwswap_dma_tb.sv
module hwswap_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_bypass = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        done, req_ready;
    logic        src_valid = 1'b1, src_ready;
    logic [15:0] src_data = '0;
    logic        sink_valid, sink_ready = 1'b1;
    logic [15:0] sink_data;
    logic        mem_burst, mem_valid, mem_ready = 1'b1, mem_write;
    logic [31:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, mem_rdata;

    int n_chk = 0, n_fail = 0, cycles = 0;

    typedef struct {
        bit          burst;
        logic [31:0] addr;
        logic [1:0]  be;
        logic [15:0] src;
        logic [15:0] expd;
    } ent_t;
    ent_t eq[$];

    always #5 clk = ~clk;

    assign mem_rdata = mem_addr[15:0] ^ 16'h5A3C;

    hwswap_dma u_dut (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bypass(req_bypass), .req_addr(req_addr), .req_len(req_len),
        .done(done), .src_valid(src_valid), .src_ready(src_ready),
        .src_data(src_data), .sink_valid(sink_valid), .sink_ready(sink_ready),
        .sink_data(sink_data), .mem_burst(mem_burst), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [15:0] swp(input logic [15:0] x);
        return {x[7:0], x[15:8]};
    endfunction

    // Expected burst/beat sequence, derived from the requirements
    task automatic build(input bit wr, input bit byp, input logic [31:0] off,
                         input int len);
        logic [31:0] a;
        int l, beat;
        a = off | base_addr;
        l = len;
        if (!byp) begin a[0] = 1'b0; l = l & ~1; end
        beat = 0;
        for (int pos = 0; pos < l; pos += 2) begin
            ent_t e;
            if (pos == 0 || (wr && !byp && (pos % 64) == 0)) begin
                e.burst = 1'b1; e.addr = a + pos; e.be = 2'b00; e.src = '0; e.expd = '0;
                eq.push_back(e);
            end
            e.burst = 1'b0;
            e.addr  = a + pos;
            e.be    = (l - pos >= 2) ? 2'b11 : 2'b01;
            e.src   = 16'h1100 + 16'(beat * 16'h0305);
            if (wr) e.expd = byp ? e.src : swp(e.src);
            else    e.expd = byp ? (e.addr[15:0] ^ 16'h5A3C) : swp(e.addr[15:0] ^ 16'h5A3C);
            eq.push_back(e);
            beat++;
        end
    endtask

    task automatic run_req(input bit wr, input bit byp, input logic [31:0] off,
                           input int len, input bit stall, input string dtag);
        int guard;
        build(wr, byp, off, len);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bypass = byp;
        req_addr = off; req_len = 16'(len);
        #1 check(req_ready == 1'b1, "R10", "req_ready at accept", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (eq.size() > 0 && guard < 2000) begin
            ent_t h;
            h = eq[0];
            mem_ready = stall ? ((guard % 3) != 2) : 1'b1;
            src_data  = h.burst ? 16'h0 : h.src;
            #1;
            if (h.burst) begin
                check(mem_burst === 1'b1, "R1/R6/R7", "burst strobe", 32'(mem_burst), 1);
                check(mem_addr === h.addr, "R1/R6", "burst address", mem_addr, h.addr);
                check(mem_valid === 1'b0, "R6", "valid during burst", 32'(mem_valid), 0);
                void'(eq.pop_front());
            end else begin
                check(mem_burst === 1'b0 && mem_valid === 1'b1, "R7/R2", "beat valid",
                      {30'd0, mem_burst, mem_valid}, 1);
                check(mem_addr === h.addr, "R2", "beat address", mem_addr, h.addr);
                check(mem_be === h.be, "R5", "byte enables", 32'(mem_be), 32'(h.be));
                check(mem_write === wr, "R3/R4", "direction", 32'(mem_write), 32'(wr));
                if (wr) begin
                    check(mem_wdata === h.expd, dtag, "write data", 32'(mem_wdata), 32'(h.expd));
                    check(src_ready === mem_ready, dtag, "src_ready", 32'(src_ready), 32'(mem_ready));
                end else begin
                    check(sink_valid === mem_ready, dtag, "sink_valid", 32'(sink_valid), 32'(mem_ready));
                    if (mem_ready)
                        check(sink_data === h.expd, dtag, "read data", 32'(sink_data), 32'(h.expd));
                end
                if (mem_ready) void'(eq.pop_front());
            end
            guard++;
            @(negedge clk);
        end
        mem_ready = 1'b1;
        #1;
        check(done === 1'b1, "R9", "done after last beat", 32'(done), 1);
        check(mem_valid === 1'b0 && mem_burst === 1'b0, "R8", "no traffic at done",
              {30'd0, mem_valid, mem_burst}, 0);
        @(negedge clk);
        #1;
        check(done === 1'b0, "R9", "done width", 32'(done), 0);
        check(req_ready === 1'b1, "R9", "ready after done", 32'(req_ready), 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(req_ready === 1'b1 && mem_valid === 1'b0 && mem_burst === 1'b0 &&
              done === 1'b0 && src_ready === 1'b0 && sink_valid === 1'b0,
              "R10", "reset outputs",
              {26'd0, req_ready, mem_valid, mem_burst, done, src_ready, sink_valid},
              32'h20);
        rst_n = 1'b1;
        base_addr = 32'h4000_0000;
        // R1 R2 R3: odd offset and odd length, swap write
        run_req(1'b1, 1'b0, 32'h0000_0013, 9, 1'b0, "R3");
        // R6: swap write over two chunks, then an exact multiple with stalls
        run_req(1'b1, 1'b0, 32'h0000_0100, 100, 1'b0, "R3");
        run_req(1'b1, 1'b0, 32'h0000_0200, 128, 1'b1, "R3");
        // R4 R7: long swap read stays one burst
        run_req(1'b0, 1'b0, 32'h0000_0301, 70, 1'b1, "R4");
        // R5: bypass write and read, odd address and odd length
        run_req(1'b1, 1'b1, 32'h0000_0405, 7, 1'b0, "R5");
        run_req(1'b0, 1'b1, 32'h0000_0503, 5, 1'b1, "R5");
        // R7: long bypass write stays one burst
        run_req(1'b1, 1'b1, 32'h0000_0600, 130, 1'b0, "R5");
        // R8: lengths that are zero after alignment
        run_req(1'b1, 1'b0, 32'h0000_0700, 1, 1'b0, "R8");
        run_req(1'b0, 1'b1, 32'h0000_0700, 0, 1'b0, "R8");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule